// File: doc/BRIEF.md
# Initiator Command Decoder

This block interprets the command bytes that a host writes into the command register of a parallel-bus initiator controller. Each command byte changes the status, interrupt-cause, sequence-step and FIFO-flag registers in its own way, and it may raise the interrupt request. The top bit of the byte chooses DMA or programmed-I/O mode. The low seven bits choose the operation. The operations are: target selection with attention (with or without a stop for the command bytes), the command-complete sequence, message accepted, bus reset, FIFO flush, enable selection, attention only, no-op and full chip reset.

The host also writes the transfer-count bytes, the target-ID register and a configuration bit through the same write port. The block looks up the selected target in a device-present vector. It does not drive the bus and it does not move data. Instead it issues single-cycle pulses: one to assert attention, one to push the two status-response bytes, and one to flag a command byte it does not recognise.

Top module: `bus_cmd_decoder`

## Requirements
- R1: After reset, irq, status, intr_cause, seq_step, fifo_flags, xfer_cnt, dma_mode, cmd_wait, resp_bytes and all pulses are 0. A write takes effect on the rising edge that samples wr_en=1, and every output is registered at that edge.
- R2: The register addresses are as follows. Address 0 stores count byte 0 (bits 7:0) and address 1 stores count byte 1 (bits 15:8); a write to either clears status bit 4 (terminal count). Address 4 stores the target ID from data bits 2:0. Address 8 stores the bus-reset report-mask bit from data bit 6. Address 3 is the command register. Writes to any other address change no output.
- R3: A recognised command with data bit 7 set sets dma_mode and copies the stored count bytes into xfer_cnt. With bit 7 clear, the command clears dma_mode and leaves xfer_cnt unchanged.
- R4: Opcode 0x01 (flush) sets intr_cause to 0x08 and clears seq_step and fifo_flags. It does not change irq.
- R5: Opcode 0x02 returns every output to its R1 value and clears the stored count bytes, target ID and mask bit, whatever the value of bit 7.
- R6: Opcode 0x03 (bus reset) sets intr_cause to 0x80. It raises irq only when the mask bit is 0.
- R7: Opcode 0x11 (complete sequence) pulses resp_push, loads resp_bytes with {0x00, sense_in}, sets intr_cause to 0x08 and raises irq. In DMA mode, status bits 6:0 become 0x17 and seq_step becomes 4. Otherwise status bits 2:0 are ORed with 7 and fifo_flags becomes 2.
- R8: Opcode 0x12 (message accepted) pulses resp_push, loads resp_bytes, sets intr_cause to 0x20 and seq_step to 0, and raises irq. In DMA mode, status bits 6:0 become 0x13. Otherwise fifo_flags becomes 2.
- R9: Opcode 0x44 clears intr_cause. Opcode 0x1a only pulses atn_pulse. Opcode 0x00 changes no register apart from the R3 mode effect.
- R10: Opcodes 0x42 and 0x43 with an absent target (dev_present bit at the target ID is 0) set status bits 6:0 to 0, intr_cause to 0x20 and seq_step to 0, and raise irq.
- R11: Opcodes 0x42 and 0x43 with a present target set intr_cause to 0x18 and seq_step to 4, and raise irq. Opcode 0x43 also sets status bits 6:0 to 0x12 and sets cmd_wait. Opcode 0x42 clears cmd_wait.
- R12: Any other opcode pulses bad_cmd and leaves every register unchanged, including dma_mode and xfer_cnt.
- R13: Status bit 7 always equals irq. irq_clear lowers irq. A command that raises irq in the same cycle wins over irq_clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 4 | Host register address |
| wr_data | input | 8 | Host write data |
| irq_clear | input | 1 | Interrupt acknowledge (interrupt register read) |
| dev_present | input | 8 | One bit per target ID, 1 = device attached |
| sense_in | input | 8 | Sense byte for the status response |
| irq | output | 1 | Interrupt request |
| status | output | 8 | Status register; bit 7 = irq, bit 4 = terminal count, bits 2:0 = phase |
| intr_cause | output | 8 | Interrupt-cause register |
| seq_step | output | 3 | Sequence-step register |
| fifo_flags | output | 5 | FIFO byte-count flags |
| xfer_cnt | output | 16 | Readable transfer counter |
| dma_mode | output | 1 | DMA mode selected by the last recognised command |
| cmd_wait | output | 1 | Waiting for command bytes after a stopping selection |
| atn_pulse | output | 1 | One-cycle attention request |
| resp_push | output | 1 | One-cycle push of the status response |
| resp_bytes | output | 16 | Response: bits 7:0 sense byte, bits 15:8 zero |
| bad_cmd | output | 1 | One-cycle unknown-opcode flag |

## Verification
Every opcode is issued with bit 7 both set and clear, so the DMA and programmed-I/O results of the response commands can be told apart, and so can a count copy and a count hold. Selections run against random presence vectors and target IDs, which separates the absent-target path from the two present-target paths. Random unknown bytes, writes to unused addresses and acknowledges that collide with commands show that nothing leaks into the registers, and that a raise wins over a clear. Directed steps cover the mask bit on bus reset and a chip reset that also clears the stored host registers.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;

    localparam int REG_W = 8;
    localparam int SEQ_W = 3;
    localparam int FLG_W = 5;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CMD   = 4'h3;
    localparam logic [ADDR_W-1:0] A_TGT   = 4'h4;
    localparam logic [ADDR_W-1:0] A_MASK  = 4'h8;

    localparam logic [6:0] OP_NOP     = 7'h00;
    localparam logic [6:0] OP_FLUSH   = 7'h01;
    localparam logic [6:0] OP_CHIPRST = 7'h02;
    localparam logic [6:0] OP_BUSRST  = 7'h03;
    localparam logic [6:0] OP_DONESEQ = 7'h11;
    localparam logic [6:0] OP_MSGOK   = 7'h12;
    localparam logic [6:0] OP_ATN     = 7'h1a;
    localparam logic [6:0] OP_SEL     = 7'h42;
    localparam logic [6:0] OP_SELSTOP = 7'h43;
    localparam logic [6:0] OP_ARM     = 7'h44;

    localparam int TC_BIT = 4;

    typedef enum logic [1:0] {
        ST_KEEP = 2'd0,
        ST_LOAD = 2'd1,
        ST_OR   = 2'd2
    } stat_op_e;

    typedef struct packed {
        logic             known;
        logic             chip_rst;
        logic             intr_we;
        logic [REG_W-1:0] intr_val;
        logic             seq_we;
        logic [SEQ_W-1:0] seq_val;
        logic             flags_we;
        logic [FLG_W-1:0] flags_val;
        stat_op_e         st_op;
        logic [6:0]       st_val;
        logic             raise;
        logic             atn;
        logic             resp;
        logic             wait_set;
        logic             wait_clr;
    } cmd_effect_t;

    function automatic cmd_effect_t effect_idle();
        cmd_effect_t e;
        e = '0;
        e.known = 1'b1;
        e.st_op = ST_KEEP;
        return e;
    endfunction

    function automatic logic [6:0] apply_status(input logic [6:0] cur,
                                                input stat_op_e op,
                                                input logic [6:0] val);
        case (op)
            ST_LOAD: return val;
            ST_OR:   return cur | val;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/host_regs.sv
module host_regs
    import bus_cmd_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int TGT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  cnt_staged,
    output logic [TGT_W-1:0]  tgt_id,
    output logic              rep_mask
);
    localparam int NBYTES = CNT_W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_cnt_byte
        always_ff @(posedge clk) begin
            if (rst || soft_rst) begin
                cnt_staged[b*8 +: 8] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(b)) begin
                cnt_staged[b*8 +: 8] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            tgt_id   <= '0;
            rep_mask <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == A_TGT)  tgt_id   <= wr_data[TGT_W-1:0];
            if (wr_addr == A_MASK) rep_mask <= wr_data[6];
        end
    end
endmodule

// File: rtl/target_lookup.sv
module target_lookup #(
    parameter int TGT_W = 3
) (
    input  logic [(1<<TGT_W)-1:0] present,
    input  logic [TGT_W-1:0]      id,
    output logic                  found
);
    localparam int N_TGT = 1 << TGT_W;
    logic [N_TGT-1:0] hit;

    for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
        assign hit[t] = present[t] && (id == TGT_W'(t));
    end

    assign found = |hit;
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
    import bus_cmd_pkg::*;
(
    input  logic [6:0]  op,
    input  logic        dma,
    input  logic        tgt_ok,
    input  logic        rep_mask,
    output cmd_effect_t eff
);
    always_comb begin
        eff = effect_idle();
        case (op)
            OP_NOP: ;
            OP_FLUSH: begin
                eff.intr_we   = 1'b1;
                eff.intr_val  = 8'h08;
                eff.seq_we    = 1'b1;
                eff.seq_val   = '0;
                eff.flags_we  = 1'b1;
                eff.flags_val = '0;
            end
            OP_CHIPRST: eff.chip_rst = 1'b1;
            OP_BUSRST: begin
                eff.intr_we  = 1'b1;
                eff.intr_val = 8'h80;
                eff.raise    = !rep_mask;
            end
            OP_DONESEQ: begin
                eff.resp     = 1'b1;
                eff.intr_we  = 1'b1;
                eff.intr_val = 8'h08;
                eff.raise    = 1'b1;
                if (dma) begin
                    eff.st_op   = ST_LOAD;
                    eff.st_val  = 7'h17;
                    eff.seq_we  = 1'b1;
                    eff.seq_val = SEQ_W'(4);
                end else begin
                    eff.st_op     = ST_OR;
                    eff.st_val    = 7'h07;
                    eff.flags_we  = 1'b1;
                    eff.flags_val = FLG_W'(2);
                end
            end
            OP_MSGOK: begin
                eff.resp     = 1'b1;
                eff.intr_we  = 1'b1;
                eff.intr_val = 8'h20;
                eff.seq_we   = 1'b1;
                eff.seq_val  = '0;
                eff.raise    = 1'b1;
                if (dma) begin
                    eff.st_op  = ST_LOAD;
                    eff.st_val = 7'h13;
                end else begin
                    eff.flags_we  = 1'b1;
                    eff.flags_val = FLG_W'(2);
                end
            end
            OP_ATN: eff.atn = 1'b1;
            OP_ARM: begin
                eff.intr_we  = 1'b1;
                eff.intr_val = 8'h00;
            end
            OP_SEL, OP_SELSTOP: begin
                eff.raise   = 1'b1;
                eff.intr_we = 1'b1;
                eff.seq_we  = 1'b1;
                if (!tgt_ok) begin
                    eff.st_op    = ST_LOAD;
                    eff.st_val   = '0;
                    eff.intr_val = 8'h20;
                    eff.seq_val  = '0;
                end else begin
                    eff.intr_val = 8'h18;
                    eff.seq_val  = SEQ_W'(4);
                    if (op == OP_SELSTOP) begin
                        eff.st_op    = ST_LOAD;
                        eff.st_val   = 7'h12;
                        eff.wait_set = 1'b1;
                    end else begin
                        eff.wait_clr = 1'b1;
                    end
                end
            end
            default: eff.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder
    import bus_cmd_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int TGT_W = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [3:0]            wr_addr,
    input  logic [7:0]            wr_data,
    input  logic                  irq_clear,
    input  logic [(1<<TGT_W)-1:0] dev_present,
    input  logic [7:0]            sense_in,
    output logic                  irq,
    output logic [7:0]            status,
    output logic [7:0]            intr_cause,
    output logic [2:0]            seq_step,
    output logic [4:0]            fifo_flags,
    output logic [CNT_W-1:0]      xfer_cnt,
    output logic                  dma_mode,
    output logic                  cmd_wait,
    output logic                  atn_pulse,
    output logic                  resp_push,
    output logic [15:0]           resp_bytes,
    output logic                  bad_cmd
);
    logic [CNT_W-1:0] cnt_staged;
    logic [TGT_W-1:0] tgt_id;
    logic             rep_mask;
    logic             tgt_ok;
    logic             cmd_stb;
    logic             soft_rst;
    logic [6:0]       st_lo;
    cmd_effect_t      eff;

    assign cmd_stb  = wr_en && (wr_addr == A_CMD);
    assign soft_rst = cmd_stb && eff.chip_rst;

    host_regs #(.CNT_W(CNT_W), .TGT_W(TGT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (soft_rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cnt_staged (cnt_staged),
        .tgt_id     (tgt_id),
        .rep_mask   (rep_mask)
    );

    target_lookup #(.TGT_W(TGT_W)) u_lookup (
        .present (dev_present),
        .id      (tgt_id),
        .found   (tgt_ok)
    );

    cmd_decode u_dec (
        .op       (wr_data[6:0]),
        .dma      (wr_data[7]),
        .tgt_ok   (tgt_ok),
        .rep_mask (rep_mask),
        .eff      (eff)
    );

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            irq        <= 1'b0;
            st_lo      <= '0;
            intr_cause <= '0;
            seq_step   <= '0;
            fifo_flags <= '0;
            xfer_cnt   <= '0;
            dma_mode   <= 1'b0;
            cmd_wait   <= 1'b0;
            atn_pulse  <= 1'b0;
            resp_push  <= 1'b0;
            resp_bytes <= '0;
            bad_cmd    <= 1'b0;
        end else begin
            atn_pulse <= 1'b0;
            resp_push <= 1'b0;
            bad_cmd   <= 1'b0;
            if (irq_clear) irq <= 1'b0;
            if (wr_en && (wr_addr == 4'h0 || wr_addr == 4'h1)) begin
                st_lo[TC_BIT] <= 1'b0;
            end
            if (cmd_stb) begin
                if (!eff.known) begin
                    bad_cmd <= 1'b1;
                end else begin
                    dma_mode <= wr_data[7];
                    if (wr_data[7]) xfer_cnt <= cnt_staged;
                    st_lo <= apply_status(st_lo, eff.st_op, eff.st_val);
                    if (eff.intr_we)  intr_cause <= eff.intr_val;
                    if (eff.seq_we)   seq_step   <= eff.seq_val;
                    if (eff.flags_we) fifo_flags <= eff.flags_val;
                    if (eff.wait_set) cmd_wait   <= 1'b1;
                    if (eff.wait_clr) cmd_wait   <= 1'b0;
                    if (eff.raise)    irq        <= 1'b1;
                    atn_pulse <= eff.atn;
                    resp_push <= eff.resp;
                    if (eff.resp) resp_bytes <= {8'h00, sense_in};
                end
            end
        end
    end

    assign status = {irq, st_lo};

    // R10: absent target on a selection
    p_absent_sel_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && (wr_data[6:0] == OP_SEL || wr_data[6:0] == OP_SELSTOP) && !tgt_ok)
        |=> (intr_cause == 8'h20 && seq_step == 3'd0 && irq && status[6:0] == 7'd0));

    // R4: flush results
    p_flush_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && wr_data[6:0] == OP_FLUSH)
        |=> (intr_cause == 8'h08 && seq_step == 3'd0 && fifo_flags == 5'd0));

    // R3: count copy on DMA command
    p_cnt_copy_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && wr_data[7] && eff.known && !eff.chip_rst)
        |=> (dma_mode && xfer_cnt == $past(cnt_staged)));

    // R12: unknown opcode leaves registers alone
    p_unknown_hold_r12: assert property (@(posedge clk) disable iff (rst)
        bad_cmd |-> ($stable(status[6:0]) && $stable(intr_cause) && $stable(seq_step)
                     && $stable(fifo_flags) && $stable(xfer_cnt) && $stable(dma_mode)));

    // R12: pulses never overlap
    p_pulse_excl_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({atn_pulse, resp_push, bad_cmd}));

    // R13: acknowledge without command lowers irq
    p_ack_r13: assert property (@(posedge clk) disable iff (rst)
        (irq_clear && !cmd_stb) |=> !irq);

    // R6: unmasked bus reset raises irq
    p_busrst_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && wr_data[6:0] == OP_BUSRST && !rep_mask)
        |=> (irq && intr_cause == 8'h80));
endmodule

// File: tb/tb_bus_cmd_decoder.sv
module tb_bus_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        irq_clear = 1'b0;
    logic [7:0]  dev_present = '0;
    logic [7:0]  sense_in = '0;
    logic        irq;
    logic [7:0]  status;
    logic [7:0]  intr_cause;
    logic [2:0]  seq_step;
    logic [4:0]  fifo_flags;
    logic [15:0] xfer_cnt;
    logic        dma_mode;
    logic        cmd_wait;
    logic        atn_pulse;
    logic        resp_push;
    logic [15:0] resp_bytes;
    logic        bad_cmd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic       m_irq;
    logic [6:0] m_st;
    logic [7:0] m_intr;
    logic [2:0] m_seq;
    logic [4:0] m_flg;
    logic [15:0] m_cnt, m_stage;
    logic       m_dma, m_wait, m_mask;
    logic [2:0] m_tgt;
    logic [15:0] m_resp;
    logic       e_atn, e_resp, e_bad;

    always #2 clk = ~clk;

    bus_cmd_decoder dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_clear(irq_clear), .dev_present(dev_present), .sense_in(sense_in),
        .irq(irq), .status(status), .intr_cause(intr_cause), .seq_step(seq_step),
        .fifo_flags(fifo_flags), .xfer_cnt(xfer_cnt), .dma_mode(dma_mode),
        .cmd_wait(cmd_wait), .atn_pulse(atn_pulse), .resp_push(resp_push),
        .resp_bytes(resp_bytes), .bad_cmd(bad_cmd)
    );

    task automatic model_reset();
        m_irq = 0; m_st = '0; m_intr = '0; m_seq = '0; m_flg = '0; m_cnt = '0;
        m_stage = '0; m_dma = 0; m_wait = 0; m_mask = 0; m_tgt = '0; m_resp = '0;
        e_atn = 0; e_resp = 0; e_bad = 0;
    endtask

    function automatic bit is_known(input logic [6:0] op);
        return op inside {7'h00, 7'h01, 7'h02, 7'h03, 7'h11, 7'h12, 7'h1a, 7'h42, 7'h43, 7'h44};
    endfunction

    task automatic model_step(input logic we, input logic [3:0] a, input logic [7:0] d,
                              input logic clr);
        logic [6:0] op;
        logic ok;
        e_atn = 0; e_resp = 0; e_bad = 0;
        if (clr) m_irq = 0;
        if (we) begin
            op = d[6:0];
            case (a)
                4'h0: begin m_stage[7:0]  = d; m_st[4] = 0; end
                4'h1: begin m_stage[15:8] = d; m_st[4] = 0; end
                4'h4: m_tgt = d[2:0];
                4'h8: m_mask = d[6];
                4'h3: begin
                    if (!is_known(op)) e_bad = 1;
                    else if (op == 7'h02) model_reset();
                    else begin
                        m_dma = d[7];
                        if (d[7]) m_cnt = m_stage;
                        ok = dev_present[m_tgt];
                        case (op)
                            7'h01: begin m_intr = 8'h08; m_seq = 0; m_flg = 0; end
                            7'h03: begin m_intr = 8'h80; if (!m_mask) m_irq = 1; end
                            7'h11: begin
                                e_resp = 1; m_resp = {8'h00, sense_in}; m_intr = 8'h08; m_irq = 1;
                                if (d[7]) begin m_st = 7'h17; m_seq = 4; end
                                else begin m_st = m_st | 7'h07; m_flg = 2; end
                            end
                            7'h12: begin
                                e_resp = 1; m_resp = {8'h00, sense_in}; m_intr = 8'h20;
                                m_seq = 0; m_irq = 1;
                                if (d[7]) m_st = 7'h13; else m_flg = 2;
                            end
                            7'h1a: e_atn = 1;
                            7'h44: m_intr = 8'h00;
                            7'h42, 7'h43: begin
                                m_irq = 1;
                                if (!ok) begin m_st = 0; m_intr = 8'h20; m_seq = 0; end
                                else begin
                                    m_intr = 8'h18; m_seq = 4;
                                    if (op == 7'h43) begin m_st = 7'h12; m_wait = 1; end
                                    else m_wait = 0;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    endtask

    function automatic logic [63:0] exp_vec();
        return {2'b0, {m_irq, m_st}, m_intr, m_seq, m_flg, m_cnt, m_dma, m_wait,
                e_atn, e_resp, m_resp, e_bad, m_irq};
    endfunction

    function automatic logic [63:0] act_vec();
        return {2'b0, status, intr_cause, seq_step, fifo_flags, xfer_cnt, dma_mode, cmd_wait,
                atn_pulse, resp_push, resp_bytes, bad_cmd, irq};
    endfunction

    task automatic check(input string tag);
        checks++;
        if (act_vec() !== exp_vec()) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act_vec(), exp_vec());
        end
    endtask

    // drive one cycle at a negedge, sample at the following negedge
    task automatic step(input logic we, input logic [3:0] a, input logic [7:0] d,
                        input logic clr, input string tag);
        wr_en = we; wr_addr = a; wr_data = d; irq_clear = clr;
        model_step(we, a, d, clr);
        @(negedge clk);
        check(tag);
        wr_en = 0; irq_clear = 0;
    endtask

    function automatic string tag_for(input logic we, input logic [3:0] a,
                                      input logic [7:0] d);
        if (!we) return "R13";
        if (a != 4'h3) return "R2";
        case (d[6:0])
            7'h01: return "R4";
            7'h02: return "R5";
            7'h03: return "R6";
            7'h11: return "R7";
            7'h12: return "R8";
            7'h42, 7'h43: return "R11";
            7'h00, 7'h1a, 7'h44: return "R9";
            default: return "R12";
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] ops [10];
        ops = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h11, 8'h12, 8'h1a, 8'h42, 8'h43, 8'h44};
        void'($urandom(32'd2024));
        model_reset();
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 reset state");

        // directed
        step(1, 4'h0, 8'h34, 0, "R2 count low");
        step(1, 4'h1, 8'h12, 0, "R2 count mid");
        step(1, 4'h5, 8'hff, 0, "R2 ignored address");
        step(1, 4'h3, 8'h80, 0, "R3 dma nop copies count");
        step(1, 4'h0, 8'h99, 0, "R2 count write");
        step(1, 4'h3, 8'h00, 0, "R3 non-dma keeps count");
        step(1, 4'h3, 8'h01, 0, "R4 flush");
        dev_present = 8'b0000_0100;
        step(1, 4'h4, 8'h03, 0, "R2 target id");
        step(1, 4'h3, 8'h42, 0, "R10 absent target");
        step(0, 4'h0, 8'h00, 1, "R13 clear");
        step(1, 4'h4, 8'h02, 0, "R2 target id");
        step(1, 4'h3, 8'h43, 0, "R11 stop selection");
        step(1, 4'h3, 8'h42, 1, "R11 R13 selection beats clear");
        step(1, 4'h1, 8'h00, 0, "R2 TC clear");
        sense_in = 8'h5a;
        step(1, 4'h3, 8'h11, 0, "R7 pio complete");
        step(1, 4'h3, 8'h91, 0, "R7 dma complete");
        sense_in = 8'hc3;
        step(1, 4'h3, 8'h12, 0, "R8 pio msg ok");
        step(1, 4'h3, 8'h92, 0, "R8 dma msg ok");
        step(1, 4'h3, 8'h44, 0, "R9 enable selection");
        step(1, 4'h3, 8'h1a, 0, "R9 attention");
        step(1, 4'h3, 8'h10, 0, "R12 unknown 0x10");
        step(1, 4'h3, 8'hff, 0, "R12 unknown 0x7f dma");
        step(0, 4'h0, 8'h00, 1, "R13 clear");
        step(1, 4'h8, 8'h40, 0, "R2 mask write");
        step(1, 4'h3, 8'h03, 0, "R6 masked bus reset");
        step(1, 4'h3, 8'h82, 0, "R5 chip reset");
        step(1, 4'h3, 8'h03, 0, "R5 R6 mask cleared by reset");

        // random
        for (int i = 0; i < 2000; i++) begin
            int r;
            logic we, clr;
            logic [3:0] a;
            logic [7:0] d;
            r = int'($urandom % 12);
            we = 1; clr = ($urandom % 6) == 0;
            a = 4'h3; d = 8'h00;
            dev_present = 8'($urandom);
            sense_in = 8'($urandom);
            if (r < 6) begin
                d = ops[$urandom % 10];
                if (d == 8'h02 && ($urandom % 4) != 0) d = 8'h11;
                d[7] = 1'($urandom);
            end else if (r == 6) begin
                d = 8'($urandom);
            end else if (r == 7) begin
                a = 4'($urandom % 2); d = 8'($urandom);
            end else if (r == 8) begin
                a = 4'h4; d = 8'($urandom);
            end else if (r == 9) begin
                a = 4'h8; d = 8'($urandom);
            end else if (r == 10) begin
                a = 4'($urandom); if (a == 4'h3) a = 4'hc; d = 8'($urandom);
            end else begin
                we = 0; clr = 1;
            end
            step(we, a, d, clr, tag_for(we, a, d));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule